// File: doc/BRIEF.md
# Compare-Match Toggle Output Timer

This block is an up-counting timer that flips the polarity of a single output each time its counter reaches a programmed compare value. Software programs a start (preload) value, a compare value, a 4-bit mode field and a set of control bits: enable, output inversion, reload behaviour and interrupt enable. The block runs only in the toggle mode, whose code is 0010. It raises a sticky compare flag on every match and requests an interrupt while that flag is set and interrupts are enabled.

The counter advances once per timer tick. A tick is either every second system clock or a pulse on a prescaler tick input, as a select input chooses. After activation, the first tick loads the preload value. Every later tick increments the counter. In reload mode, the tick that follows a match loads the preload value again, which gives a steady square wave. In free-run mode the counter keeps counting past the compare value and wraps through zero. The output therefore toggles again only after a full trip round the counter.

Top module: `cmp_toggle_timer`

## Requirements
- R1: The timer is active only when `enable` is 1 and `mode` equals 4'b0010. While it is inactive, `count` is held at 0 and ticks are ignored.
- R2: While the timer is inactive, `tmr_out` follows `invert` one clock later, so it starts at the inversion value when the timer is enabled. Changing `invert` while the timer is active has no effect on `tmr_out`.
- R3: The first timer tick after activation loads `preload` into `count`.
- R4: Every later tick without a pending reload increments `count` by one, and 24'hFFFFFF wraps to 0.
- R5: When a tick gives `count` a value equal to `compare` (a load included), `tmr_out` inverts on the same clock edge. In no other case does `tmr_out` change while the timer is active.
- R6: `flag` is set on every match and cleared by a one-cycle pulse on `flag_clr`. A match in the same cycle as a clear leaves `flag` set. `flag` persists while the timer is disabled.
- R7: `irq` is high exactly when `flag` and `irq_en` are both 1, and it follows `irq_en` without a clock delay.
- R8: With `reload_mode` set, the tick after a match loads `preload` again. Successive output edges are therefore `compare - preload + 1` ticks apart, and when `preload` equals `compare` the output toggles on every tick.
- R9: With `reload_mode` clear, the tick after a match increments `count` rather than reloading it.
- R10: With `clk_sel`=0, a tick occurs on every second system clock edge, the first on the second edge after activation. With `clk_sel`=1, a tick occurs on each edge at which `tick_pre` is 1.
- R11: The active-low asynchronous reset clears `count`, `tmr_out` and `flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Timer enable bit |
| mode | input | 4 | Mode field; toggle mode is 4'b0010 |
| invert | input | 1 | Output level applied at enable |
| reload_mode | input | 1 | 1: reload preload after a match; 0: free-run |
| irq_en | input | 1 | Interrupt enable |
| clk_sel | input | 1 | 0: tick every second clock; 1: use tick_pre |
| tick_pre | input | 1 | Tick pulse from the prescaler |
| preload | input | 24 | Start and reload value |
| compare | input | 24 | Compare value |
| flag_clr | input | 1 | Write-one pulse that clears the flag |
| tmr_out | output | 1 | Toggling timer output |
| irq | output | 1 | Compare interrupt request |
| flag | output | 1 | Sticky compare flag |
| count | output | 24 | Current counter value |

## Verification
A compare match and a software clear of the flag can occur on the same clock edge. Likewise, a reload and a match occur together when the preload equals the compare value. The stimulus table pulses `flag_clr` together with the tick that brings the count to the compare value, and it expects the flag to remain set and the output to toggle. It also pulses `flag_clr` on a tick that does not match, and expects the flag to fall. A directed case with equal preload and compare values expects a toggle on every tick while the count stays constant.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        TICK_DIV2 = 1'b0,
        TICK_EXT  = 1'b1
    } tick_src_e;

    typedef struct packed {
        logic out;
        logic flag;
    } pin_state_t;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic src_sel,
    input  logic pre_tick,
    output logic tick
);

    logic half_d, half_q;

    always_comb begin
        half_d = 1'b0;
        if (active) begin
            half_d = ~half_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= half_d;
        end
    end

    always_comb begin
        tick = 1'b0;
        if (active) begin
            if (tick_src_e'(src_sel) == TICK_EXT) begin
                tick = pre_tick;
            end else begin
                tick = half_q;
            end
        end
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] preload,
    input  logic [CNT_W-1:0] compare,
    output logic [CNT_W-1:0] count,
    output logic             match
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             reload_due;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        match = 1'b0;
        if (!active) begin
            st_d = '0;
        end else if (tick) begin
            if (!st_q.armed || st_q.reload_due) begin
                st_d.cnt = preload;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.armed      = 1'b1;
            match           = (st_d.cnt == compare);
            st_d.reload_due = match & reload_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/tmr_out_flag.sv
module tmr_out_flag
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic invert,
    input  logic match,
    input  logic flag_clr,
    input  logic irq_en,
    output logic pin,
    output logic flag,
    output logic irq
);

    pin_state_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (!active) begin
            ps_d.out = invert;
        end else if (match) begin
            ps_d.out = ~ps_q.out;
        end
        if (match) begin
            ps_d.flag = 1'b1;
        end else if (flag_clr) begin
            ps_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign pin  = ps_q.out;
    assign flag = ps_q.flag;
    assign irq  = ps_q.flag & irq_en;

endmodule

// File: rtl/cmp_toggle_timer.sv
module cmp_toggle_timer #(
    parameter int unsigned          CNT_W       = 24,
    parameter int unsigned          MODE_W      = 4,
    parameter logic [MODE_W-1:0]    TOGGLE_CODE = 4'b0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [MODE_W-1:0] mode,
    input  logic              invert,
    input  logic              reload_mode,
    input  logic              irq_en,
    input  logic              clk_sel,
    input  logic              tick_pre,
    input  logic [CNT_W-1:0]  preload,
    input  logic [CNT_W-1:0]  compare,
    input  logic              flag_clr,
    output logic              tmr_out,
    output logic              irq,
    output logic              flag,
    output logic [CNT_W-1:0]  count
);

    logic active;
    logic tick;
    logic match;

    assign active = enable && (mode == TOGGLE_CODE);

    tmr_tick_gen u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .src_sel  (clk_sel),
        .pre_tick (tick_pre),
        .tick     (tick)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick),
        .reload_en (reload_mode),
        .preload   (preload),
        .compare   (compare),
        .count     (count),
        .match     (match)
    );

    tmr_out_flag u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .invert   (invert),
        .match    (match),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .pin      (tmr_out),
        .flag     (flag),
        .irq      (irq)
    );

endmodule

// File: rtl/tmr_timer_checker.sv
module tmr_timer_checker #(
    parameter int unsigned          CNT_W       = 24,
    parameter int unsigned          MODE_W      = 4,
    parameter logic [MODE_W-1:0]    TOGGLE_CODE = 4'b0010
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [MODE_W-1:0] mode,
    input logic              invert,
    input logic              irq_en,
    input logic              flag_clr,
    input logic [CNT_W-1:0]  compare,
    input logic [CNT_W-1:0]  count,
    input logic              tmr_out,
    input logic              flag,
    input logic              irq
);

    logic act;
    assign act = enable && (mode == TOGGLE_CODE);

    p_idle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (count == '0));

    p_idle_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (tmr_out == $past(invert)));

    p_toggle_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) && count == $past(compare) && count != $past(count))
        |-> (tmr_out != $past(tmr_out)));

    p_hold_without_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) && count == $past(count) && count != $past(compare))
        |-> (tmr_out == $past(tmr_out)));

    p_flag_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) && count == $past(compare) && count != $past(count))
        |-> flag);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

endmodule

bind cmp_toggle_timer tmr_timer_checker #(
    .CNT_W       (CNT_W),
    .MODE_W      (MODE_W),
    .TOGGLE_CODE (TOGGLE_CODE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .mode     (mode),
    .invert   (invert),
    .irq_en   (irq_en),
    .flag_clr (flag_clr),
    .compare  (compare),
    .count    (count),
    .tmr_out  (tmr_out),
    .flag     (flag),
    .irq      (irq)
);

// File: tb/test_cmp_toggle_timer.sv
module test_cmp_toggle_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [3:0]  mode = 4'b0010;
    logic        invert = 1'b0;
    logic        reload_mode = 1'b1;
    logic        irq_en = 1'b1;
    logic        clk_sel = 1'b1;
    logic        tick_pre = 1'b0;
    logic [23:0] preload = 24'd5;
    logic [23:0] compare = 24'd7;
    logic        flag_clr = 1'b0;
    logic        tmr_out;
    logic        irq;
    logic        flag;
    logic [23:0] count;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_toggle_timer i_cmp_toggle_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .mode        (mode),
        .invert      (invert),
        .reload_mode (reload_mode),
        .irq_en      (irq_en),
        .clk_sel     (clk_sel),
        .tick_pre    (tick_pre),
        .preload     (preload),
        .compare     (compare),
        .flag_clr    (flag_clr),
        .tmr_out     (tmr_out),
        .irq         (irq),
        .flag        (flag),
        .count       (count)
    );

    // vector fields: {tick, clear, count[7:0], out, flag}
    // preload 5, compare 7, reload on, irq_en 1, external ticks
    localparam logic [11:0] VEC [10] = '{
        {1'b1, 1'b0, 8'd5, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'd5, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'd6, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'd7, 1'b1, 1'b1},
        {1'b1, 1'b0, 8'd5, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'd6, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'd7, 1'b0, 1'b1},
        {1'b1, 1'b1, 8'd5, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'd6, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'd7, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic c);
        tick_pre = t;
        flag_clr = c;
        @(negedge clk);
        tick_pre = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        idle(2);
        // R11: reset state
        chk("R11 count", {8'h0, count}, 32'h0);
        chk("R11 out", {31'h0, tmr_out}, 32'h0);
        chk("R11 flag", {31'h0, flag}, 32'h0);
        rst_n = 1'b1;
        idle(1);

        enable = 1'b1;
        idle(1);
        chk("R1 count before first tick", {8'h0, count}, 32'h0);
        chk("R2 out at enable", {31'h0, tmr_out}, 32'h0);

        // table: R3 load, R4 increment, R5 toggle, R6 flag/clear race, R8 reload, R7 irq
        for (int i = 0; i < 10; i++) begin
            step(VEC[i][11], VEC[i][10]);
            chk($sformatf("R3/R4/R8 count row %0d", i), {8'h0, count}, {24'h0, VEC[i][9:2]});
            chk($sformatf("R5 out row %0d", i), {31'h0, tmr_out}, {31'h0, VEC[i][1]});
            chk($sformatf("R6 flag row %0d", i), {31'h0, flag}, {31'h0, VEC[i][0]});
            chk($sformatf("R7 irq row %0d", i), {31'h0, irq}, {31'h0, VEC[i][0]});
        end

        // R7: irq follows irq_en without delay
        irq_en = 1'b0;
        #1;
        chk("R7 irq masked", {31'h0, irq}, 32'h0);
        irq_en = 1'b1;
        #1;
        chk("R7 irq unmasked", {31'h0, irq}, 32'h1);
        @(negedge clk);

        // R6 sticky across disable, R1 count cleared
        enable = 1'b0;
        idle(1);
        chk("R1 count cleared on disable", {8'h0, count}, 32'h0);
        chk("R6 flag sticky while disabled", {31'h0, flag}, 32'h1);
        step(1'b0, 1'b1);
        chk("R6 flag cleared", {31'h0, flag}, 32'h0);

        // R2: inversion value applied at enable, later changes ignored
        invert = 1'b1;
        idle(1);
        chk("R2 out follows invert while idle", {31'h0, tmr_out}, 32'h1);
        enable = 1'b1;
        step(1'b1, 1'b0);
        chk("R3 load after enable", {8'h0, count}, 32'd5);
        chk("R2 out starts at invert", {31'h0, tmr_out}, 32'h1);
        invert = 1'b0;
        step(1'b0, 1'b0);
        chk("R2 invert change ignored", {31'h0, tmr_out}, 32'h1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk("R5 toggle from inverted start", {31'h0, tmr_out}, 32'h0);

        // R1: wrong mode code ignores ticks
        enable = 1'b0;
        step(1'b0, 1'b1);
        mode = 4'b0011;
        enable = 1'b1;
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk("R1 other mode count", {8'h0, count}, 32'h0);
        chk("R1 other mode flag", {31'h0, flag}, 32'h0);
        chk("R1 other mode out", {31'h0, tmr_out}, 32'h0);

        // R4 wrap and R9 free-run
        enable = 1'b0;
        idle(1);
        mode = 4'b0010;
        reload_mode = 1'b0;
        preload = 24'hFFFFFE;
        compare = 24'h000000;
        enable = 1'b1;
        step(1'b1, 1'b0);
        chk("R3 load high value", {8'h0, count}, 32'hFFFFFE);
        step(1'b1, 1'b0);
        chk("R4 count all ones", {8'h0, count}, 32'hFFFFFF);
        step(1'b1, 1'b0);
        chk("R4 wrap to zero", {8'h0, count}, 32'h0);
        chk("R5 toggle at wrap match", {31'h0, tmr_out}, 32'h1);
        chk("R6 flag at wrap match", {31'h0, flag}, 32'h1);
        step(1'b1, 1'b0);
        chk("R9 no reload in free-run", {8'h0, count}, 32'h1);
        chk("R9 out held after match", {31'h0, tmr_out}, 32'h1);

        // R8: preload equal to compare toggles every tick
        enable = 1'b0;
        step(1'b0, 1'b1);
        reload_mode = 1'b1;
        preload = 24'd9;
        compare = 24'd9;
        enable = 1'b1;
        step(1'b1, 1'b0);
        chk("R8 equal values first", {31'h0, tmr_out}, 32'h1);
        step(1'b1, 1'b0);
        chk("R8 equal values second", {31'h0, tmr_out}, 32'h0);
        chk("R8 equal values count", {8'h0, count}, 32'd9);
        step(1'b1, 1'b0);
        chk("R8 equal values third", {31'h0, tmr_out}, 32'h1);

        // R10: internal divide-by-two tick
        enable = 1'b0;
        idle(1);
        clk_sel = 1'b0;
        preload = 24'd3;
        compare = 24'd100;
        enable = 1'b1;
        idle(1);
        chk("R10 no tick on first edge", {8'h0, count}, 32'h0);
        idle(1);
        chk("R10 tick on second edge", {8'h0, count}, 32'd3);
        idle(1);
        chk("R10 no tick on third edge", {8'h0, count}, 32'd3);
        idle(1);
        chk("R10 tick on fourth edge", {8'h0, count}, 32'd4);

        // R11: asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        chk("R11 async count", {8'h0, count}, 32'h0);
        chk("R11 async out", {31'h0, tmr_out}, 32'h0);
        chk("R11 async flag", {31'h0, flag}, 32'h0);
        idle(1);
        rst_n = 1'b1;
        idle(1);

        done = 1'b1;
        finish_run();
    end

endmodule